// File: doc/BRIEF.md
# DSI Host Command Packet Packer

This block turns one command request for a DSI host transmitter into a stream of 32-bit FIFO words. A request carries a virtual channel, a data type, a payload length, a low-power flag, an acknowledge-request flag and the length of any read response that is expected. The payload bytes then arrive one per handshake on a byte stream.

The first word out is the packet header. It carries the channel, the data type and the first two payload bytes. Every later word packs the next four payload bytes, lowest byte first.

While the words stream out, the block holds three per-packet attributes steady:
- which FIFO the packet belongs in (the small host FIFO or the larger video FIFO),
- whether it goes out in high-speed mode,
- whether a bus turnaround must follow it.

A request that is too long for the video FIFO is consumed and rejected without emitting anything. When the final word is accepted, the block pulses a done strobe and reports the byte count transmitted for a write. A busy flag covers the whole packet, so that control firmware can poll for completion.

ECC, checksum and lane serialisation belong to later stages. The word stream uses a valid/ready handshake and a last marker.

Top module: `dsi_cmd_packer`

## Requirements
- R1: The header word carries the data type in bits 5:0, the virtual channel in bits 7:6, payload byte 0 in bits 15:8 and payload byte 1 in bits 23:16. Bits 31:24 are zero, and a byte slot beyond the payload length is zero.
- R2: Payload bytes from index 2 onward are packed four per word, little-endian: byte 2+4k+j goes to bits 8j+7:8j of word k+1. Unused slots of the final word are zero. A request of length L > 2 yields 1 + ceil((L-2)/4) words; a request of length L ≤ 2 yields one word.
- R3: A zero-length request produces only the header word, with bits 23:8 cleared and the last marker set. It consumes no payload byte.
- R4: A request whose length exceeds 4*VID_WORDS bytes (1024 by default) is consumed but emits no word. It pulses reject_o for exactly the one cycle after the acceptance edge, and busy_o stays low.
- R5: out_video_o is 1 exactly when the length exceeds 4*HOST_WORDS bytes (256 by default, with HOST_WORDS = 64).
- R6: out_bta_o is 1 when the acknowledge flag is set or the expected read length is nonzero.
- R7: out_hs_o is the inverse of the low-power flag.
- R8: For an accepted request, count_o equals 4 plus the payload length. It is valid while done_o pulses, in the cycle after the last word is accepted.
- R9: busy_o rises in the cycle after a request is accepted and falls in the cycle after the last word is accepted.
- R10: While out_valid_o is high and out_ready_i is low, out_valid_o stays high and out_data_o and out_last_o hold their values.
- R11: out_last_o is set on the final word of a packet and on no other word.
- R12: req_ready_o is low while a packet is in progress, so no new request is taken until the current one completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted at this edge when valid |
| req_vc_i | input | 2 | Virtual channel |
| req_dt_i | input | 6 | Data type |
| req_len_i | input | LEN_W | Payload length in bytes |
| req_lp_i | input | 1 | Send in low-power mode |
| req_ack_i | input | 1 | Acknowledge requested |
| req_rx_len_i | input | LEN_W | Expected read response length |
| pld_valid_i | input | 1 | Payload byte valid |
| pld_ready_o | output | 1 | Payload byte taken at this edge when valid |
| pld_data_i | input | 8 | Payload byte |
| out_valid_o | output | 1 | FIFO word valid |
| out_ready_i | input | 1 | FIFO word accepted |
| out_data_o | output | 32 | FIFO word |
| out_last_o | output | 1 | Final word of packet |
| out_video_o | output | 1 | Packet goes to the video FIFO |
| out_hs_o | output | 1 | High-speed transmission |
| out_bta_o | output | 1 | Bus turnaround after packet |
| busy_o | output | 1 | Packet in progress |
| reject_o | output | 1 | Request rejected (one-cycle pulse) |
| done_o | output | 1 | Packet complete (one-cycle pulse) |
| count_o | output | LEN_W+1 | Bytes transmitted |

## Verification
The results are due at these times:
- reject_o and the rise of busy_o appear in the cycle after the edge that accepts a request.
- Each word and its attributes are checked when out_valid_o is seen with the bench's own out_ready_i high, since that word then transfers at the next edge.
- done_o, count_o and the fall of busy_o are due one cycle after the edge that accepts the last word.

The bench drives all inputs and samples all outputs on the falling edge. It decides each handshake from values that change only on the rising edge, so every check lands on the cycle its result is due. Random stalls on both streams also exercise the hold rule on the word output.

// File: rtl/dsi_cmd_pkg.sv
package dsi_cmd_pkg;
  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned HDR_BYTES  = 2;

  typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_SEND} pk_state_e;

  typedef struct packed {
    logic video;
    logic hs;
    logic bta;
  } pk_attr_t;
endpackage

// File: rtl/dsi_cmd_decode.sv
module dsi_cmd_decode
  import dsi_cmd_pkg::*;
#(
  parameter int unsigned LEN_W      = 16,
  parameter int unsigned HOST_WORDS = 64,
  parameter int unsigned VID_WORDS  = 256,
  localparam int unsigned CNT_W     = LEN_W + 1
) (
  input  logic [LEN_W-1:0] len_i,
  input  logic             lp_i,
  input  logic             ack_i,
  input  logic [LEN_W-1:0] rx_len_i,
  output pk_attr_t         attr_o,
  output logic             reject_o,
  output logic [CNT_W-1:0] count_o
);
  localparam int unsigned HOST_BYTES = WORD_BYTES * HOST_WORDS;
  localparam int unsigned VID_BYTES  = WORD_BYTES * VID_WORDS;

  always_comb begin
    reject_o     = 32'(len_i) > VID_BYTES;
    attr_o.video = 32'(len_i) > HOST_BYTES;
    attr_o.hs    = ~lp_i;
    attr_o.bta   = ack_i | (rx_len_i != '0);
    count_o      = CNT_W'(len_i) + CNT_W'(WORD_BYTES);
  end
endmodule

// File: rtl/dsi_cmd_word_asm.sv
module dsi_cmd_word_asm
  import dsi_cmd_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [1:0]  vc_i,
  input  logic [5:0]  dt_i,
  input  logic        next_i,
  input  logic        byte_we_i,
  input  logic [7:0]  byte_i,
  input  logic        last_byte_i,
  output logic [31:0] word_o,
  output logic        word_done_o
);
  localparam int unsigned SLOT_W = $clog2(WORD_BYTES);

  logic              hdr_q;
  logic [SLOT_W-1:0] slot_q;
  logic [SLOT_W-1:0] lane_sel;
  logic [7:0]        lane_q [WORD_BYTES];

  // header word reserves lane 0 for channel and type
  assign lane_sel    = hdr_q ? slot_q + SLOT_W'(1) : slot_q;
  assign word_done_o = byte_we_i &&
                       (last_byte_i || slot_q == (hdr_q ? SLOT_W'(HDR_BYTES - 1)
                                                        : SLOT_W'(WORD_BYTES - 1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hdr_q  <= 1'b0;
      slot_q <= '0;
    end else if (start_i) begin
      hdr_q  <= 1'b1;
      slot_q <= '0;
    end else if (next_i) begin
      hdr_q  <= 1'b0;
      slot_q <= '0;
    end else if (byte_we_i) begin
      slot_q <= slot_q + SLOT_W'(1);
    end
  end

  for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               lane_q[g] <= '0;
      else if (start_i)                          lane_q[g] <= (g == 0) ? {vc_i, dt_i} : 8'h00;
      else if (next_i)                           lane_q[g] <= '0;
      else if (byte_we_i && lane_sel == SLOT_W'(g)) lane_q[g] <= byte_i;
    end
    assign word_o[8*g +: 8] = lane_q[g];
  end

  // R1: header never takes more than two payload bytes
  a_r1_hdr_slots: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_we_i && hdr_q) |-> (slot_q < SLOT_W'(HDR_BYTES)));
  // R1: top byte of header stays clear
  a_r1_hdr_top_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_q |-> (word_o[31:24] == 8'h00));
endmodule

// File: rtl/dsi_cmd_packer.sv
module dsi_cmd_packer
  import dsi_cmd_pkg::*;
#(
  parameter int unsigned LEN_W      = 16,
  parameter int unsigned HOST_WORDS = 64,
  parameter int unsigned VID_WORDS  = 256,
  localparam int unsigned CNT_W     = LEN_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [1:0]       req_vc_i,
  input  logic [5:0]       req_dt_i,
  input  logic [LEN_W-1:0] req_len_i,
  input  logic             req_lp_i,
  input  logic             req_ack_i,
  input  logic [LEN_W-1:0] req_rx_len_i,
  input  logic             pld_valid_i,
  output logic             pld_ready_o,
  input  logic [7:0]       pld_data_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [31:0]      out_data_o,
  output logic             out_last_o,
  output logic             out_video_o,
  output logic             out_hs_o,
  output logic             out_bta_o,
  output logic             busy_o,
  output logic             reject_o,
  output logic             done_o,
  output logic [CNT_W-1:0] count_o
);
  pk_state_e        state_q;
  pk_attr_t         attr_q, dec_attr;
  logic             dec_reject;
  logic [CNT_W-1:0] dec_count, cnt_q;
  logic [LEN_W-1:0] rem_q;
  logic             last_q, reject_q, done_q;
  logic             req_fire, pld_fire, out_fire, word_done;

  dsi_cmd_decode #(
    .LEN_W(LEN_W), .HOST_WORDS(HOST_WORDS), .VID_WORDS(VID_WORDS)
  ) u_decode (
    .len_i(req_len_i), .lp_i(req_lp_i), .ack_i(req_ack_i), .rx_len_i(req_rx_len_i),
    .attr_o(dec_attr), .reject_o(dec_reject), .count_o(dec_count)
  );

  assign req_ready_o = (state_q == ST_IDLE);
  assign pld_ready_o = (state_q == ST_FILL);
  assign out_valid_o = (state_q == ST_SEND);
  assign req_fire    = req_valid_i && req_ready_o;
  assign pld_fire    = pld_valid_i && pld_ready_o;
  assign out_fire    = out_valid_o && out_ready_i;

  dsi_cmd_word_asm u_asm (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .start_i(req_fire && !dec_reject), .vc_i(req_vc_i), .dt_i(req_dt_i),
    .next_i(out_fire && !last_q),
    .byte_we_i(pld_fire), .byte_i(pld_data_i), .last_byte_i(rem_q == LEN_W'(1)),
    .word_o(out_data_o), .word_done_o(word_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      attr_q   <= '0;
      cnt_q    <= '0;
      rem_q    <= '0;
      last_q   <= 1'b0;
      reject_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      reject_q <= 1'b0;
      done_q   <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_fire) begin
          if (dec_reject) begin
            reject_q <= 1'b1;
          end else begin
            attr_q <= dec_attr;
            cnt_q  <= dec_count;
            rem_q  <= req_len_i;
            last_q <= (req_len_i == '0);
            state_q <= (req_len_i == '0) ? ST_SEND : ST_FILL;
          end
        end
        ST_FILL: if (pld_fire) begin
          rem_q <= rem_q - LEN_W'(1);
          if (word_done) begin
            state_q <= ST_SEND;
            last_q  <= (rem_q == LEN_W'(1));
          end
        end
        ST_SEND: if (out_ready_i) begin
          if (last_q) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            state_q <= ST_FILL;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign out_last_o  = last_q;
  assign out_video_o = attr_q.video;
  assign out_hs_o    = attr_q.hs;
  assign out_bta_o   = attr_q.bta;
  assign busy_o      = (state_q != ST_IDLE);
  assign reject_o    = reject_q;
  assign done_o      = done_q;
  assign count_o     = cnt_q;

  a_r10_hold_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o) && $stable(out_last_o)));
  a_r8_done_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(out_valid_o && out_ready_i && out_last_o));
  a_r4_reject_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject_o |-> (!busy_o && !out_valid_o && $past(req_valid_i && req_ready_o)));
  a_r9_busy_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(req_valid_i && req_ready_o));
  a_r5_attr_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(out_video_o) && $stable(out_hs_o) && $stable(out_bta_o)));
  a_r11_more_after_mid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i && !out_last_o) |=> busy_o);
  a_r12_streams_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pld_ready_o && out_valid_o));
endmodule

// File: tb/tb_dsi_cmd_packer.sv
module tb_dsi_cmd_packer;
  localparam int LEN_W = 16;
  localparam int CNT_W = LEN_W + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_lp = 0, req_ack = 0;
  logic [1:0] req_vc = 0;
  logic [5:0] req_dt = 0;
  logic [LEN_W-1:0] req_len = 0, req_rx = 0;
  logic pld_valid = 0, out_ready = 0;
  logic [7:0] pld_data = 0;
  logic req_ready, pld_ready, out_valid, out_last, out_video, out_hs, out_bta;
  logic busy, reject, done;
  logic [31:0] out_data;
  logic [CNT_W-1:0] count;

  int checks = 0, fails = 0;
  logic [7:0] pay [2048];

  always #2 clk = ~clk;

  dsi_cmd_packer dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_vc_i(req_vc), .req_dt_i(req_dt),
    .req_len_i(req_len), .req_lp_i(req_lp), .req_ack_i(req_ack), .req_rx_len_i(req_rx),
    .pld_valid_i(pld_valid), .pld_ready_o(pld_ready), .pld_data_i(pld_data),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data), .out_last_o(out_last),
    .out_video_o(out_video), .out_hs_o(out_hs), .out_bta_o(out_bta),
    .busy_o(busy), .reject_o(reject), .done_o(done), .count_o(count)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input logic [1:0] vc, input logic [5:0] dt,
                                           input int len, input int w);
    logic [31:0] r = '0;
    if (w == 0) begin
      r[7:0] = {vc, dt};
      if (len > 0) r[15:8]  = pay[0];
      if (len > 1) r[23:16] = pay[1];
    end else begin
      for (int k = 0; k < 4; k++) begin
        int idx = 2 + 4 * (w - 1) + k;
        if (idx < len) r[8*k +: 8] = pay[idx];
      end
    end
    return r;
  endfunction

  task automatic run_pkt(input logic [1:0] vc, input logic [5:0] dt, input int len,
                         input bit lp, input bit ack, input int rx, input int stall_pct);
    int nw, bi, wi, guard;
    bit fin, stalled;
    logic [31:0] sdata, ew;
    bit exp_rej = len > 1024;
    nw = (len <= 2) ? 1 : 1 + (len - 2 + 3) / 4;
    if (!exp_rej) for (int i = 0; i < len; i++) pay[i] = 8'($urandom);
    req_vc = vc; req_dt = dt; req_len = LEN_W'(len); req_lp = lp; req_ack = ack;
    req_rx = LEN_W'(rx); req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (exp_rej) begin
      chk(reject == 1'b1, "R4 reject pulse", 32'(reject), 1);
      chk(busy == 1'b0 && out_valid == 1'b0, "R4 no packet", {busy, out_valid}, 0);
      @(negedge clk);
      chk(reject == 1'b0, "R4 single pulse", 32'(reject), 0);
      chk(out_valid == 1'b0, "R4 no word", 32'(out_valid), 0);
      return;
    end
    chk(busy == 1'b1, "R9 busy rise", 32'(busy), 1);
    chk(req_ready == 1'b0, "R12 no accept while busy", 32'(req_ready), 0);
    bi = 0; wi = 0; fin = 0; guard = 0; stalled = 0; sdata = '0;
    while (!fin && guard < 20000) begin
      if (stalled)
        chk(out_valid && out_data == sdata, "R10 hold on stall", out_data, sdata);
      if (pld_ready && bi < len && ($urandom % 100) >= 20) begin
        pld_valid = 1'b1; pld_data = pay[bi]; bi++;
      end else begin
        pld_valid = 1'b0;
      end
      out_ready = (($urandom % 100) >= 32'(stall_pct));
      stalled = 0;
      if (out_valid) begin
        if (out_ready) begin
          ew = exp_word(vc, dt, len, wi);
          chk(out_data == ew, (wi == 0) ? (len == 0 ? "R3 empty header" : "R1 header")
                                        : "R2 payload word", out_data, ew);
          chk(out_last == (wi == nw - 1), "R11 last marker", 32'(out_last), 32'(wi == nw - 1));
          if (wi == 0) begin
            chk(out_video == (len > 256), "R5 fifo select", 32'(out_video), 32'(len > 256));
            chk(out_hs == !lp, "R7 high speed", 32'(out_hs), 32'(!lp));
            chk(out_bta == (ack || rx != 0), "R6 turnaround", 32'(out_bta), 32'(ack || rx != 0));
          end
          if (out_last) fin = 1;
          wi++;
        end else begin
          stalled = 1; sdata = out_data;
        end
      end
      @(negedge clk);
      guard++;
    end
    pld_valid = 1'b0; out_ready = 1'b0;
    if (!fin) chk(0, "R2 packet incomplete", 32'(wi), 32'(nw));
    chk(wi == nw, "R2 word count", 32'(wi), 32'(nw));
    chk(bi == len, "R3 bytes consumed", 32'(bi), 32'(len));
    chk(done == 1'b1 && count == CNT_W'(len + 4), "R8 count", 32'(count), 32'(len + 4));
    chk(busy == 1'b0, "R9 busy fall", 32'(busy), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(busy == 0 && out_valid == 0 && req_ready == 1 && pld_ready == 0, "R9 reset state",
        {busy, out_valid, req_ready, pld_ready}, 32'b0010);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 0 && reject == 0, "R4 reset pulses", {done, reject}, 0);
    run_pkt(2'd1, 6'h05, 0, 0, 0, 0, 0);
    run_pkt(2'd3, 6'h15, 1, 1, 0, 0, 30);
    run_pkt(2'd0, 6'h39, 2, 0, 1, 0, 0);
    run_pkt(2'd2, 6'h29, 3, 0, 0, 4, 40);
    run_pkt(2'd1, 6'h39, 6, 1, 1, 2, 10);
    run_pkt(2'd0, 6'h39, 256, 0, 0, 0, 20);
    run_pkt(2'd0, 6'h39, 257, 0, 0, 0, 20);
    run_pkt(2'd3, 6'h29, 1024, 1, 0, 0, 10);
    run_pkt(2'd0, 6'h39, 1025, 0, 0, 0, 0);
    run_pkt(2'd1, 6'h39, 4000, 0, 1, 0, 0);
    for (int n = 0; n < 40; n++)
      run_pkt(2'($urandom), 6'($urandom), int'($urandom % 400), 1'($urandom), 1'($urandom),
              (($urandom % 3) == 0) ? int'($urandom % 8) : 0, int'($urandom % 50));
    run_pkt(2'd2, 6'h05, 0, 1, 1, 1, 60);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule